// File: doc/BRIEF.md
# Reset Sequencing Controller

This block merges two reset sources into a set of reset outputs, one for each group of logic in the chip. The first source is an active-low reset pin. The second is a two-bit operating-mode field that software can set to a soft-reset code. The block sends each outcome to its own output:

- **Pin-state reset:** a reset for the output pins that takes effect the moment the pin falls, even before any clock runs.
- **Core reset:** a reset in the video clock domain that stays asserted for a long fixed window after the last source clears.
- **Serial-bus control register reset:** a reset for that register, asserted only while the pin itself is in reset.

The core-reset hold window doubles as the memory initialization window. For the whole window the block requests a memory initialization sequence and keeps memory refresh disabled. When the window ends, it gives a one-cycle completion pulse and enables refresh. If a new reset source appears during the window, the hold count starts again once that source clears.

Top module: `rst_seq_ctrl`

## Requirements
- R1: While `ext_rst_n` is low, the outputs `pad_rst`, `core_rst` and `ctl_reg_rst` are 1, `refresh_en` is 0 and `mem_init_req` is 0. These values appear as soon as the pin falls, with no clock edge needed.
- R2: Mode code 2'b11 is the soft-reset code. `core_rst` is 1 after the first rising clock edge that samples `op_mode` = 2'b11.
- R3: Mode codes 2'b00, 2'b01 and 2'b10 all mean normal operation. With the pin high, they never assert `core_rst`.
- R4: After `ext_rst_n` rises, `ctl_reg_rst` is still 1 after the first clock edge and 0 after the second. `core_rst` stays 1 for 2 + HOLD_CYCLES cycles in total, where HOLD_CYCLES defaults to 7562.
- R5: After `op_mode` leaves 2'b11, `core_rst` stays 1 for exactly HOLD_CYCLES cycles and is 0 from the next cycle.
- R6: A soft reset on its own never asserts `ctl_reg_rst`.
- R7: `mem_init_req` is 1 in exactly the HOLD_CYCLES cycles of the hold window after the last source clears. It is 0 at all other times.
- R8: `refresh_en` is 0 in every cycle where `core_rst` is 1, and 1 once `core_rst` is 0.
- R9: If a reset source appears during the hold window, the window restarts. `core_rst` then stays 1 for the full count measured from the new release.
- R10: `rst_done` is a single-cycle pulse, high in the first cycle in which `core_rst` is 0.
- R11: With the pin high, `pad_rst` equals `core_rst`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Video clock |
| ext_rst_n | input | 1 | External active-low reset pin |
| op_mode | input | 2 | Operating-mode field: 2'b11 means soft reset, all other codes mean operate |
| pad_rst | output | 1 | Pin-state reset, asserted asynchronously |
| core_rst | output | 1 | Core-domain reset, stretched by the hold window |
| ctl_reg_rst | output | 1 | Serial-bus control register reset, driven by the pin only |
| mem_init_req | output | 1 | Memory initialization request for the hold window |
| refresh_en | output | 1 | Memory refresh enable |
| rst_done | output | 1 | One-cycle pulse when the core reset ends |

## Verification
The assertions assume that `op_mode` changes only between clock edges. They also assume that every low pulse on `ext_rst_n` lasts at least one full clock cycle, so that each pin reset is seen by at least one edge while the asynchronous clear is active. The stimulus keeps to both assumptions: it changes every input on a falling clock edge, except in the one directed case where the pin falls mid-cycle. Reset pulses and soft-reset pulses last from one to eight whole cycles. Re-triggers are drawn at random points inside the hold window, in both pin and soft form.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

    typedef enum logic [1:0] {
        OPM_RUN  = 2'b00,
        OPM_ALTA = 2'b01,
        OPM_ALTB = 2'b10,
        OPM_SOFT = 2'b11
    } op_mode_e;

    function automatic logic mode_is_soft(input logic [1:0] m);
        return op_mode_e'(m) == OPM_SOFT;
    endfunction

endpackage

// File: rtl/rstseq_sync.sv
module rstseq_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    output logic rel_n
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_single
            always_comb sh_d = 1'b1;
        end else begin : g_chain
            always_comb sh_d = {sh_q[STAGES-2:0], 1'b1};
        end
    endgenerate

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) sh_q <= '0;
        else         sh_q <= sh_d;
    end

    assign rel_n = sh_q[LAST];
endmodule

// File: rtl/rstseq_mode_dec.sv
module rstseq_mode_dec
    import rstseq_pkg::*;
(
    input  logic [1:0] op_mode,
    output logic       soft_req
);
    always_comb begin
        unique case (op_mode_e'(op_mode))
            OPM_SOFT: soft_req = 1'b1;
            default:  soft_req = mode_is_soft(op_mode);
        endcase
    end
endmodule

// File: rtl/rstseq_hold.sv
module rstseq_hold #(
    parameter int HOLD = 7562,
    localparam int CW  = $clog2(HOLD + 1)
) (
    input  logic clk,
    input  logic arst_n,
    input  logic src,
    output logic core,
    output logic init_req,
    output logic done
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          core;
        logic          init;
        logic          done;
    } hold_st_t;

    localparam logic [CW-1:0] LOAD = CW'(HOLD);
    localparam hold_st_t ST_RST = '{cnt: LOAD, core: 1'b1, init: 1'b0, done: 1'b0};

    hold_st_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (src) begin
            s_d.cnt  = LOAD;
            s_d.core = 1'b1;
            s_d.init = 1'b0;
        end else begin
            s_d.core = (s_q.cnt != '0);
            s_d.init = (s_q.cnt != '0);
            s_d.cnt  = (s_q.cnt != '0) ? s_q.cnt - CW'(1) : '0;
        end
        s_d.done = s_q.core & ~s_d.core;
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) s_q <= ST_RST;
        else         s_q <= s_d;
    end

    assign core     = s_q.core;
    assign init_req = s_q.init;
    assign done     = s_q.done;
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
    parameter int HOLD_CYCLES = 7562,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       ext_rst_n,
    input  logic [1:0] op_mode,
    output logic       pad_rst,
    output logic       core_rst,
    output logic       ctl_reg_rst,
    output logic       mem_init_req,
    output logic       refresh_en,
    output logic       rst_done
);
    logic pin_rel_n;
    logic soft_req;
    logic src;
    logic core_w;

    rstseq_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .arst_n (ext_rst_n),
        .rel_n  (pin_rel_n)
    );

    rstseq_mode_dec u_mode (
        .op_mode  (op_mode),
        .soft_req (soft_req)
    );

    assign src = ~pin_rel_n | soft_req;

    rstseq_hold #(.HOLD(HOLD_CYCLES)) u_hold (
        .clk      (clk),
        .arst_n   (ext_rst_n),
        .src      (src),
        .core     (core_w),
        .init_req (mem_init_req),
        .done     (rst_done)
    );

    assign core_rst    = core_w;
    assign pad_rst     = ~ext_rst_n | core_w;
    assign ctl_reg_rst = ~pin_rel_n;
    assign refresh_en  = ~core_w;
endmodule

// File: rtl/rst_seq_ctrl_chk.sv
module rst_seq_ctrl_chk #(
    parameter int HOLD_CYCLES = 7562,
    localparam int GW = $clog2(HOLD_CYCLES + 3)
) (
    input logic       clk,
    input logic       ext_rst_n,
    input logic [1:0] op_mode,
    input logic       core_rst,
    input logic       ctl_reg_rst,
    input logic       mem_init_req,
    input logic       rst_done,
    input logic       src
);
    logic [GW-1:0] gap_q;

    always_ff @(posedge clk or negedge ext_rst_n) begin
        if (!ext_rst_n)    gap_q <= '0;
        else if (src)      gap_q <= '0;
        else if (core_rst) gap_q <= gap_q + GW'(1);
    end

    // R2
    soft_enters_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        (op_mode == 2'b11) |=> core_rst);

    // R6
    ctl_no_soft_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        !$rose(ctl_reg_rst));

    // R7
    init_in_core_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        mem_init_req |-> core_rst);

    // R5
    hold_len_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(core_rst) |-> (gap_q == GW'(HOLD_CYCLES + 1)));

    // R10
    done_on_fall_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        $fell(core_rst) |-> rst_done);

    // R10
    done_single_chk: assert property (@(posedge clk) disable iff (!ext_rst_n)
        rst_done |=> !rst_done);
endmodule

bind rst_seq_ctrl rst_seq_ctrl_chk #(.HOLD_CYCLES(HOLD_CYCLES)) u_chk (
    .clk          (clk),
    .ext_rst_n    (ext_rst_n),
    .op_mode      (op_mode),
    .core_rst     (core_rst),
    .ctl_reg_rst  (ctl_reg_rst),
    .mem_init_req (mem_init_req),
    .rst_done     (rst_done),
    .src          (src)
);

// File: tb/sim_rst_seq_ctrl.sv
`timescale 1ns/100ps
module sim_rst_seq_ctrl;
    localparam int HOLD = 7562;
    localparam int SYNC = 2;

    logic       clk = 1'b0;
    logic       clk_on = 1'b0;
    logic       ext_rst_n;
    logic [1:0] op_mode;
    logic       pad_rst, core_rst, ctl_reg_rst, mem_init_req, refresh_en, rst_done;

    int n_chk  = 0;
    int n_fail = 0;

    rst_seq_ctrl #(.HOLD_CYCLES(HOLD), .SYNC_STAGES(SYNC)) u0 (
        .clk          (clk),
        .ext_rst_n    (ext_rst_n),
        .op_mode      (op_mode),
        .pad_rst      (pad_rst),
        .core_rst     (core_rst),
        .ctl_reg_rst  (ctl_reg_rst),
        .mem_init_req (mem_init_req),
        .refresh_en   (refresh_en),
        .rst_done     (rst_done)
    );

    initial begin
        wait (clk_on);
        forever #2 clk = ~clk;
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic int exp_core_cycles(input bit by_pin);
        return by_pin ? HOLD + SYNC : HOLD;
    endfunction

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Called right after the last source was removed on a falling edge.
    task automatic measure(input bit by_pin);
        int c = 0, mi = 0, bad_ref = 0, bad_ctl = 0, bad_pad = 0, ctl1 = -1, ctl2 = -1;
        forever begin
            @(negedge clk);
            if (!core_rst || c > HOLD + 20) break;
            c++;
            if (refresh_en) bad_ref++;
            if (mem_init_req) mi++;
            if (pad_rst != core_rst) bad_pad++;
            if (c == 1) ctl1 = int'(ctl_reg_rst);
            if (c == 2) ctl2 = int'(ctl_reg_rst);
            if (!by_pin && ctl_reg_rst) bad_ctl++;
        end
        if (by_pin) begin
            chk(c == exp_core_cycles(1), "R4", "core cycles after pin release", c, exp_core_cycles(1));
            chk(ctl1 == 1 && ctl2 == 0, "R4", "ctl after edge1*10+edge2", ctl1 * 10 + ctl2, 10);
        end else begin
            chk(c == exp_core_cycles(0), "R5", "core cycles after soft release", c, exp_core_cycles(0));
            chk(bad_ctl == 0, "R6", "ctl high cycles in soft reset", bad_ctl, 0);
        end
        chk(mi == HOLD, "R7", "init request cycles", mi, HOLD);
        chk(bad_ref == 0, "R8", "refresh high during core reset", bad_ref, 0);
        chk(bad_pad == 0, "R11", "pad differs from core", bad_pad, 0);
        chk(rst_done == 1'b1, "R10", "done at first idle cycle", int'(rst_done), 1);
        chk(pad_rst == 1'b0, "R11", "pad after core ends", int'(pad_rst), 0);
        @(negedge clk);
        chk(rst_done == 1'b0, "R10", "done second cycle", int'(rst_done), 0);
        chk(refresh_en == 1'b1, "R8", "refresh after done", int'(refresh_en), 1);
        chk(mem_init_req == 1'b0, "R7", "init after done", int'(mem_init_req), 0);
    endtask

    task automatic pin_pulse(input int len);
        ext_rst_n = 1'b0;
        cyc(len);
        ext_rst_n = 1'b1;
    endtask

    task automatic soft_pulse(input int len);
        op_mode = 2'b11;
        cyc(len);
        op_mode = 2'b00;
    endtask

    initial begin
        int junk_hi;
        ext_rst_n = 1'b1;
        op_mode   = 2'b00;
        #1 ext_rst_n = 1'b0;
        #1;
        // R1: no clock running yet
        chk(pad_rst && core_rst && ctl_reg_rst, "R1", "resets asserted without clock",
            int'({pad_rst, core_rst, ctl_reg_rst}), 7);
        chk(!refresh_en && !mem_init_req, "R1", "refresh/init low in reset",
            int'({refresh_en, mem_init_req}), 0);
        clk_on = 1'b1;
        cyc(5);
        ext_rst_n = 1'b1;
        measure(1);

        // R1: pin falls mid-cycle
        @(posedge clk);
        #1 ext_rst_n = 1'b0;
        #0.5;
        chk(pad_rst && core_rst && ctl_reg_rst && !refresh_en, "R1", "mid-cycle async assert",
            int'({pad_rst, core_rst, ctl_reg_rst, refresh_en}), 14);
        cyc(3);
        ext_rst_n = 1'b1;
        measure(1);

        // R2 / R6: soft reset
        op_mode = 2'b11;
        @(negedge clk);
        chk(core_rst == 1'b1, "R2", "core after first soft edge", int'(core_rst), 1);
        chk(ctl_reg_rst == 1'b0, "R6", "ctl in soft reset", int'(ctl_reg_rst), 0);
        cyc(4);
        op_mode = 2'b00;
        measure(0);

        // R3: codes 01 and 10 act as run
        junk_hi = 0;
        op_mode = 2'b01;
        repeat (20) begin
            @(negedge clk);
            if (core_rst || pad_rst) junk_hi++;
        end
        op_mode = 2'b10;
        repeat (20) begin
            @(negedge clk);
            if (core_rst || pad_rst) junk_hi++;
        end
        op_mode = 2'b00;
        chk(junk_hi == 0, "R3", "reset cycles under codes 01/10", junk_hi, 0);

        // R9: directed re-trigger by soft reset
        pin_pulse(3);
        cyc(3000);
        chk(core_rst == 1'b1, "R9", "core still held mid-window", int'(core_rst), 1);
        soft_pulse(3);
        measure(0);

        // R9: random episodes with fixed seed
        void'($urandom(32'h5EED_0042));
        for (int ep = 0; ep < 6; ep++) begin
            bit kind  = 1'($urandom % 2);
            bit retr  = 1'($urandom % 2);
            int len   = 1 + int'($urandom % 8);
            op_mode = kind ? 2'($urandom % 3) : 2'b00;
            if (kind) pin_pulse(len); else soft_pulse(len);
            op_mode = 2'b00;
            if (retr) begin
                int at = 3 + int'($urandom % (HOLD - 10));
                cyc(at);
                chk(core_rst == 1'b1, "R9", "core held before re-trigger", int'(core_rst), 1);
                kind = 1'($urandom % 2);
                len  = 1 + int'($urandom % 8);
                if (kind) pin_pulse(len); else soft_pulse(len);
            end
            measure(kind);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(4 * 190000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule